// File: doc/BRIEF.md
# Link-Layer Flow-Control Initialisation Sequencer

This block takes a link layer from reset to the active state. It waits until the physical layer reports that the link is up. It then trades initial flow-control credit values with the far end of the link. While the sequencer is in its first phase, it keeps sending advertisement requests that carry the local header and data buffer sizes. The requests go out in a fixed rotation: posted, then non-posted, then completion. The sequencer also records the partner's advertised values for each of these three traffic categories.

When the partner's values for all three categories have been recorded, the sequencer finishes its current rotation and moves to a confirmation phase. In that phase it sends confirmation requests in the same rotation. It declares the link active once the partner is seen either confirming or sending packet traffic. Packet traffic is allowed only while the active indication is high. If the link-up input drops at any time, the sequencer returns to the idle state and forgets what it recorded.

Each outgoing request is a valid/ready stream item. A request stays on the outputs unchanged until `tx_ready` accepts it. The one exception is a change of phase or a loss of link, which withdraws it. Received link messages arrive as single-cycle strobes and are never back-pressured. The message encoder and CRC sit downstream of this block.

Top module: `fcinit_ctrl`

## Requirements
- R1: After reset, `dl_state` is idle (code 0), and `link_active`, `tx_valid` and all `ptr_valid` bits are low. The block stays idle while `link_up` is low.
- R2: When `link_up` is high in the idle state, `dl_state` becomes first phase (code 1) on the next cycle. In that cycle `tx_valid` is high, `tx_phase` is 0 and `tx_cat` is posted (code 0).
- R3: Category codes are posted 0, non-posted 1 and completion 2. Each accepted request (`tx_valid` and `tx_ready` both high at a clock edge) advances `tx_cat` from 0 to 1 to 2 and back to 0. This holds in both phases.
- R4: Every request carries the local credits of its own category. Category c uses lane bits `[c*HDR_W +: HDR_W]` of `loc_hdr_cr` and lane bits `[c*DAT_W +: DAT_W]` of `loc_dat_cr`.
- R5: While `tx_ready` is low, a pending request stays valid with an unchanged category and phase. It is withdrawn only when the phase changes or the link is lost.
- R6: In the first phase, a strobe with `rx_kind` = 2'b01 and `rx_cat` in the range 0..2 stores `rx_hdr_cr` and `rx_dat_cr` into that category's lane of `ptr_hdr_cr` and `ptr_dat_cr`, and sets `ptr_valid[rx_cat]`. The result is visible on the next cycle. A later strobe for the same category overwrites the lane.
- R7: The first phase ends only on an accepted completion-category request made while all three `ptr_valid` bits are set. On the next cycle, `dl_state` is confirmation phase (code 2), `tx_phase` is 1 and `tx_cat` is 0. Until then the rotation keeps repeating.
- R8: In the confirmation phase, a strobe with `rx_kind` = 2'b10 (any category) or a high `rx_tlp` makes `dl_state` active (code 3) on the next cycle. While the block is active, `link_active` is high and `tx_valid` stays low.
- R9: Some inputs are ignored. A first-phase strobe outside the first phase, any strobe with `rx_kind` 2'b00 or 2'b11, and a strobe with `rx_cat` 3 change no recorded value. A confirmation strobe during the first phase does not change the state.
- R10: When `link_up` is low, `dl_state` becomes idle on the next cycle from any state. On that same cycle all `ptr_valid` bits and all recorded credits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Physical layer reports a trained link |
| rx_valid | input | 1 | Strobe for a received link message |
| rx_kind | input | 2 | 01 first-phase advertisement, 10 confirmation, others unrelated |
| rx_cat | input | 2 | Category of the received message (0 posted, 1 non-posted, 2 completion) |
| rx_hdr_cr | input | HDR_W | Partner header credits in the message |
| rx_dat_cr | input | DAT_W | Partner data credits in the message |
| rx_tlp | input | 1 | Partner packet traffic observed |
| loc_hdr_cr | input | 3*HDR_W | Local header credits, one lane per category |
| loc_dat_cr | input | 3*DAT_W | Local data credits, one lane per category |
| tx_valid | output | 1 | Request to send an initialisation message |
| tx_ready | input | 1 | Downstream encoder accepts the request |
| tx_phase | output | 1 | 0 advertisement, 1 confirmation |
| tx_cat | output | 2 | Category of the request |
| tx_hdr_cr | output | HDR_W | Local header credits for the request |
| tx_dat_cr | output | DAT_W | Local data credits for the request |
| ptr_valid | output | 3 | Partner value recorded, one bit per category |
| ptr_hdr_cr | output | 3*HDR_W | Recorded partner header credits |
| ptr_dat_cr | output | 3*DAT_W | Recorded partner data credits |
| link_active | output | 1 | Link layer active, packets permitted |
| dl_state | output | 2 | 0 idle, 1 first phase, 2 confirmation, 3 active |

## Verification
Each result is registered once, so it is due exactly one cycle after its cause. A state change, a recorded credit and a cleared lane all appear on the cycle after the strobe or the handshake edge that caused them. The request outputs change in the same cycle as the state or category register behind them. The bench drives inputs on the falling edge and reads the results on the following falling edge, which places every check one full register stage after its stimulus. Requests are released by holding `tx_ready` high for a counted number of edges. Each release is preceded by pushing the same number of expected items onto the scoreboard, so every handshake the monitor sees is matched against a known category, phase and credit pair.

// File: rtl/fcinit_pkg.sv
package fcinit_pkg;
  localparam int unsigned NUM_CAT = 3;
  localparam int unsigned CAT_W   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADV   = 2'd1,
    ST_CONF  = 2'd2,
    ST_UP    = 2'd3
  } dl_state_e;

  localparam logic [1:0] KIND_ADV  = 2'b01;
  localparam logic [1:0] KIND_CONF = 2'b10;

  localparam logic [CAT_W-1:0] CAT_POST = 2'd0;
  localparam logic [CAT_W-1:0] CAT_NONP = 2'd1;
  localparam logic [CAT_W-1:0] CAT_CPL  = 2'd2;
endpackage

// File: rtl/fcinit_seq.sv
module fcinit_seq
  import fcinit_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      link_up,
  input  logic      all_got,
  input  logic      round_done,
  input  logic      confirm_seen,
  output dl_state_e state_o
);
  dl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!link_up) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_ADV;
        ST_ADV:  if (round_done && all_got) state_d = ST_CONF;
        ST_CONF: if (confirm_seen) state_d = ST_UP;
        ST_UP:   state_d = ST_UP;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/fcinit_txsched.sv
module fcinit_txsched
  import fcinit_pkg::*;
#(
  parameter int unsigned HDR_W = 8,
  parameter int unsigned DAT_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  dl_state_e                  state,
  input  logic                       tx_ready,
  input  logic [NUM_CAT*HDR_W-1:0]   loc_hdr_cr,
  input  logic [NUM_CAT*DAT_W-1:0]   loc_dat_cr,
  output logic                       tx_valid,
  output logic                       tx_phase,
  output logic [CAT_W-1:0]           tx_cat,
  output logic [HDR_W-1:0]           tx_hdr_cr,
  output logic [DAT_W-1:0]           tx_dat_cr,
  output logic                       round_done
);
  logic [CAT_W-1:0] cur_q;
  logic             sending;
  logic             accept;
  logic [HDR_W-1:0] hdr_lane [NUM_CAT];
  logic [DAT_W-1:0] dat_lane [NUM_CAT];

  for (genvar c = 0; c < NUM_CAT; c++) begin : g_lane
    assign hdr_lane[c] = loc_hdr_cr[c*HDR_W +: HDR_W];
    assign dat_lane[c] = loc_dat_cr[c*DAT_W +: DAT_W];
  end

  assign sending    = (state == ST_ADV) || (state == ST_CONF);
  assign accept     = sending && tx_ready;
  assign round_done = accept && (cur_q == CAT_CPL);

  always_ff @(posedge clk) begin
    if (!rst_n || !sending) begin
      cur_q <= CAT_POST;
    end else if (accept) begin
      cur_q <= (cur_q == CAT_CPL) ? CAT_POST : cur_q + 2'd1;
    end
  end

  always_comb begin
    tx_hdr_cr = hdr_lane[0];
    tx_dat_cr = dat_lane[0];
    unique case (cur_q)
      CAT_NONP: begin
        tx_hdr_cr = hdr_lane[1];
        tx_dat_cr = dat_lane[1];
      end
      CAT_CPL: begin
        tx_hdr_cr = hdr_lane[2];
        tx_dat_cr = dat_lane[2];
      end
      default: ;
    endcase
  end

  assign tx_valid = sending;
  assign tx_phase = (state == ST_CONF);
  assign tx_cat   = cur_q;
endmodule

// File: rtl/fcinit_capture.sv
module fcinit_capture
  import fcinit_pkg::*;
#(
  parameter int unsigned HDR_W = 8,
  parameter int unsigned DAT_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     link_up,
  input  logic                     cap_en,
  input  logic [CAT_W-1:0]         rx_cat,
  input  logic [HDR_W-1:0]         rx_hdr_cr,
  input  logic [DAT_W-1:0]         rx_dat_cr,
  output logic [NUM_CAT-1:0]       got,
  output logic [NUM_CAT*HDR_W-1:0] ptr_hdr_cr,
  output logic [NUM_CAT*DAT_W-1:0] ptr_dat_cr
);
  for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
    logic             hit;
    logic             got_q;
    logic [HDR_W-1:0] hdr_q;
    logic [DAT_W-1:0] dat_q;

    assign hit = cap_en && (rx_cat == CAT_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n || !link_up) begin
        got_q <= 1'b0;
        hdr_q <= '0;
        dat_q <= '0;
      end else if (hit) begin
        got_q <= 1'b1;
        hdr_q <= rx_hdr_cr;
        dat_q <= rx_dat_cr;
      end
    end

    assign got[c]                      = got_q;
    assign ptr_hdr_cr[c*HDR_W +: HDR_W] = hdr_q;
    assign ptr_dat_cr[c*DAT_W +: DAT_W] = dat_q;
  end
endmodule

// File: rtl/fcinit_ctrl.sv
module fcinit_ctrl
  import fcinit_pkg::*;
#(
  parameter int unsigned HDR_W = 8,
  parameter int unsigned DAT_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     link_up,
  input  logic                     rx_valid,
  input  logic [1:0]               rx_kind,
  input  logic [1:0]               rx_cat,
  input  logic [HDR_W-1:0]         rx_hdr_cr,
  input  logic [DAT_W-1:0]         rx_dat_cr,
  input  logic                     rx_tlp,
  input  logic [3*HDR_W-1:0]       loc_hdr_cr,
  input  logic [3*DAT_W-1:0]       loc_dat_cr,
  output logic                     tx_valid,
  input  logic                     tx_ready,
  output logic                     tx_phase,
  output logic [1:0]               tx_cat,
  output logic [HDR_W-1:0]         tx_hdr_cr,
  output logic [DAT_W-1:0]         tx_dat_cr,
  output logic [2:0]               ptr_valid,
  output logic [3*HDR_W-1:0]       ptr_hdr_cr,
  output logic [3*DAT_W-1:0]       ptr_dat_cr,
  output logic                     link_active,
  output logic [1:0]               dl_state
);
  dl_state_e state;
  logic      round_done;
  logic      all_got;
  logic      confirm_seen;
  logic      cap_en;

  // Partner advertisements are recorded only in the first phase.
  assign cap_en       = rx_valid && (rx_kind == KIND_ADV) && (state == ST_ADV);
  assign confirm_seen = (rx_valid && (rx_kind == KIND_CONF)) || rx_tlp;
  assign all_got      = &ptr_valid;

  fcinit_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_up      (link_up),
    .all_got      (all_got),
    .round_done   (round_done),
    .confirm_seen (confirm_seen),
    .state_o      (state)
  );

  fcinit_txsched #(.HDR_W(HDR_W), .DAT_W(DAT_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .tx_ready   (tx_ready),
    .loc_hdr_cr (loc_hdr_cr),
    .loc_dat_cr (loc_dat_cr),
    .tx_valid   (tx_valid),
    .tx_phase   (tx_phase),
    .tx_cat     (tx_cat),
    .tx_hdr_cr  (tx_hdr_cr),
    .tx_dat_cr  (tx_dat_cr),
    .round_done (round_done)
  );

  fcinit_capture #(.HDR_W(HDR_W), .DAT_W(DAT_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_up    (link_up),
    .cap_en     (cap_en),
    .rx_cat     (rx_cat),
    .rx_hdr_cr  (rx_hdr_cr),
    .rx_dat_cr  (rx_dat_cr),
    .got        (ptr_valid),
    .ptr_hdr_cr (ptr_hdr_cr),
    .ptr_dat_cr (ptr_dat_cr)
  );

  assign link_active = (state == ST_UP);
  assign dl_state    = state;
endmodule

// File: rtl/fcinit_sva.sv
module fcinit_sva #(
  parameter int unsigned HDR_W = 8,
  parameter int unsigned DAT_W = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       link_up,
  input logic       rx_valid,
  input logic [1:0] rx_kind,
  input logic [1:0] rx_cat,
  input logic       rx_tlp,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_phase,
  input logic [1:0] tx_cat,
  input logic [2:0] ptr_valid,
  input logic       link_active,
  input logic [1:0] dl_state
);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_state == 2'd0 && !link_up) |=> (dl_state == 2'd0 && !tx_valid));

  assert_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_state == 2'd0 && link_up) |=> (dl_state == 2'd1 && tx_valid && tx_cat == 2'd0));

  assert_post_to_nonp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && link_up && tx_cat == 2'd0) |=> (!tx_valid || tx_cat == 2'd1));

  assert_cpl_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && link_up && tx_cat == 2'd2) |=> (!tx_valid || tx_cat == 2'd0));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_state == 2'd1 && tx_valid && !tx_ready && link_up)
      |=> (tx_valid && $stable(tx_cat) && $stable(tx_phase)));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_state == 2'd1 && link_up && rx_valid && rx_kind == 2'b01 && rx_cat == 2'd2)
      |=> ptr_valid[2]);

  assert_conf_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_state == 2'd2) |-> (ptr_valid == 3'b111));

  assert_tlp_activates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_state == 2'd2 && link_up && rx_tlp) |=> link_active);

  assert_quiet_when_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_active && tx_valid));

  assert_drop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (dl_state == 2'd0 && ptr_valid == 3'b000));
endmodule

bind fcinit_ctrl fcinit_sva #(.HDR_W(HDR_W), .DAT_W(DAT_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .link_up     (link_up),
  .rx_valid    (rx_valid),
  .rx_kind     (rx_kind),
  .rx_cat      (rx_cat),
  .rx_tlp      (rx_tlp),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_phase    (tx_phase),
  .tx_cat      (tx_cat),
  .ptr_valid   (ptr_valid),
  .link_active (link_active),
  .dl_state    (dl_state)
);

// File: tb/tb_fcinit_ctrl.sv
`timescale 1ns/1ps
module tb_fcinit_ctrl;
  localparam int HDR_W = 8;
  localparam int DAT_W = 12;

  logic               clk = 1'b0;
  logic               rst_n, link_up, rx_valid, rx_tlp, tx_ready;
  logic [1:0]         rx_kind, rx_cat;
  logic [HDR_W-1:0]   rx_hdr_cr;
  logic [DAT_W-1:0]   rx_dat_cr;
  logic [3*HDR_W-1:0] loc_hdr_cr;
  logic [3*DAT_W-1:0] loc_dat_cr;
  logic               tx_valid, tx_phase, link_active;
  logic [1:0]         tx_cat, dl_state;
  logic [HDR_W-1:0]   tx_hdr_cr;
  logic [DAT_W-1:0]   tx_dat_cr;
  logic [2:0]         ptr_valid;
  logic [3*HDR_W-1:0] ptr_hdr_cr;
  logic [3*DAT_W-1:0] ptr_dat_cr;

  always #2 clk = ~clk;

  fcinit_ctrl #(.HDR_W(HDR_W), .DAT_W(DAT_W)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic             ph;
    logic [1:0]       cat;
    logic [HDR_W-1:0] h;
    logic [DAT_W-1:0] d;
  } item_t;
  item_t exp_q[$];

  function automatic logic [HDR_W-1:0] lh(int c);
    return HDR_W'(8'h20 + c);
  endfunction
  function automatic logic [DAT_W-1:0] ld(int c);
    return DAT_W'(12'h300 + 17 * c);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic ph, int c);
    item_t it;
    it.ph  = ph;
    it.cat = 2'(c);
    it.h   = lh(c);
    it.d   = ld(c);
    exp_q.push_back(it);
  endtask

  // Called at a falling edge: n handshakes follow.
  task automatic release_ready(int n);
    tx_ready = 1'b1;
    repeat (n) @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic rx_strobe(logic [1:0] k, logic [1:0] c, logic [HDR_W-1:0] h, logic [DAT_W-1:0] d);
    rx_valid  = 1'b1;
    rx_kind   = k;
    rx_cat    = c;
    rx_hdr_cr = h;
    rx_dat_cr = d;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_kind  = 2'b00;
  endtask

  // Scoreboard monitor: a handshake at the coming rising edge pops one item.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R3 unexpected request actual=%0h expected=none", tx_cat);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk("R3", "tx_cat", tx_cat, e.cat);
          chk("R7", "tx_phase", tx_phase, e.ph);
          chk("R4", "tx_hdr_cr", tx_hdr_cr, e.h);
          chk("R4", "tx_dat_cr", tx_dat_cr, e.d);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; link_up = 1'b0; rx_valid = 1'b0; rx_tlp = 1'b0; tx_ready = 1'b0;
    rx_kind = 2'b00; rx_cat = 2'b00; rx_hdr_cr = '0; rx_dat_cr = '0;
    for (int c = 0; c < 3; c++) begin
      loc_hdr_cr[c*HDR_W +: HDR_W] = lh(c);
      loc_dat_cr[c*DAT_W +: DAT_W] = ld(c);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "dl_state", dl_state, 0);
    chk("R1", "link_active", link_active, 0);
    chk("R1", "tx_valid", tx_valid, 0);
    chk("R1", "ptr_valid", ptr_valid, 0);
    repeat (3) @(negedge clk);
    chk("R1", "idle hold", dl_state, 0);

    link_up = 1'b1;
    @(negedge clk);
    chk("R2", "dl_state", dl_state, 1);
    chk("R2", "tx_valid", tx_valid, 1);
    chk("R2", "tx_phase", tx_phase, 0);
    chk("R2", "tx_cat", tx_cat, 0);
    chk("R4", "tx_hdr_cr", tx_hdr_cr, lh(0));
    repeat (3) @(negedge clk);
    chk("R5", "stall valid", tx_valid, 1);
    chk("R5", "stall cat", tx_cat, 0);

    rx_strobe(2'b01, 2'd2, 8'hA2, 12'hB02);
    chk("R6", "ptr_valid", ptr_valid, 3'b100);
    chk("R6", "hdr lane2", ptr_hdr_cr[2*HDR_W +: HDR_W], 8'hA2);
    chk("R6", "dat lane2", ptr_dat_cr[2*DAT_W +: DAT_W], 12'hB02);
    rx_strobe(2'b01, 2'd0, 8'hA0, 12'hB00);
    rx_strobe(2'b01, 2'd0, 8'hA5, 12'hB05);
    chk("R6", "overwrite hdr lane0", ptr_hdr_cr[0 +: HDR_W], 8'hA5);
    chk("R6", "overwrite dat lane0", ptr_dat_cr[0 +: DAT_W], 12'hB05);
    rx_strobe(2'b01, 2'd3, 8'hEE, 12'hEEE);
    chk("R9", "cat3 ignored", ptr_valid, 3'b101);
    rx_strobe(2'b10, 2'd1, 8'hEE, 12'hEEE);
    chk("R9", "confirm in phase one", dl_state, 1);
    chk("R9", "confirm not captured", ptr_valid, 3'b101);

    for (int i = 0; i < 6; i++) push(1'b0, i % 3);
    release_ready(6);
    chk("R7", "incomplete stays", dl_state, 1);
    chk("R3", "rotation back", tx_cat, 0);

    rx_strobe(2'b01, 2'd1, 8'hA1, 12'hB01);
    chk("R6", "ptr_valid full", ptr_valid, 3'b111);
    chk("R6", "hdr lane1", ptr_hdr_cr[HDR_W +: HDR_W], 8'hA1);
    chk("R7", "waits round end", dl_state, 1);
    push(1'b0, 0); push(1'b0, 1);
    release_ready(2);
    chk("R7", "mid round", dl_state, 1);
    chk("R3", "cat at cpl", tx_cat, 2);
    push(1'b0, 2);
    release_ready(1);
    chk("R7", "dl_state", dl_state, 2);
    chk("R7", "tx_phase", tx_phase, 1);
    chk("R7", "tx_cat", tx_cat, 0);

    rx_strobe(2'b01, 2'd0, 8'h5A, 12'h05A);
    chk("R9", "late adv lane0", ptr_hdr_cr[0 +: HDR_W], 8'hA5);
    rx_strobe(2'b11, 2'd0, 8'h00, 12'h000);
    chk("R9", "other kind", dl_state, 2);
    push(1'b1, 0); push(1'b1, 1);
    release_ready(2);
    chk("R3", "conf rotation", tx_cat, 2);
    chk("R3", "conf state", dl_state, 2);

    rx_strobe(2'b10, 2'd0, 8'h00, 12'h000);
    chk("R8", "dl_state", dl_state, 3);
    chk("R8", "link_active", link_active, 1);
    chk("R8", "tx_valid", tx_valid, 0);
    rx_strobe(2'b01, 2'd2, 8'h77, 12'h777);
    chk("R9", "adv when active", ptr_hdr_cr[2*HDR_W +: HDR_W], 8'hA2);
    release_ready(3);

    link_up = 1'b0;
    @(negedge clk);
    chk("R10", "dl_state", dl_state, 0);
    chk("R10", "ptr_valid", ptr_valid, 0);
    chk("R10", "hdr cleared", ptr_hdr_cr, 0);
    chk("R10", "dat cleared", ptr_dat_cr, 0);
    chk("R10", "link_active", link_active, 0);

    link_up = 1'b1;
    @(negedge clk);
    chk("R2", "second wake", dl_state, 1);
    rx_strobe(2'b01, 2'd0, 8'h10, 12'h010);
    rx_strobe(2'b01, 2'd1, 8'h11, 12'h011);
    rx_strobe(2'b01, 2'd2, 8'h12, 12'h012);
    for (int i = 0; i < 3; i++) push(1'b0, i);
    release_ready(3);
    chk("R7", "second conf", dl_state, 2);
    rx_tlp = 1'b1;
    @(negedge clk);
    rx_tlp = 1'b0;
    chk("R8", "tlp activates", dl_state, 3);
    chk("R8", "tlp link_active", link_active, 1);

    link_up = 1'b0;
    @(negedge clk);
    link_up = 1'b1;
    @(negedge clk);
    rx_strobe(2'b01, 2'd0, 8'h33, 12'h033);
    chk("R6", "third capture", ptr_valid, 3'b001);
    link_up = 1'b0;
    @(negedge clk);
    chk("R10", "drop in phase one", dl_state, 0);
    chk("R10", "drop clears", ptr_valid, 0);
    chk("R10", "drop withdraws", tx_valid, 0);

    chk("R3", "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule